// File: doc/BRIEF.md
# Skew-Aligning TDM Serial Receiver

This block recovers bytes from a group of serial time-division-multiplexed input lanes running at one quarter of the system clock rate. Each frame starts at a one-clock frame pulse. Each frame holds a configurable number of 8-bit channels per lane. The block counts system clocks from the pulse and samples each lane once per bit cell. It assembles eight samples into a byte and hands the byte out with its channel number and a one-clock valid strobe.

Board traces and drivers skew each lane differently. To absorb this, every lane has its own 5-bit delay code in quarter-bit steps, up to 31 quarter-bits (almost eight bits). One global control chooses whether a lane is sampled three quarters or halfway into its (delayed) bit cell. Delay codes and the sampling choice are captured at the frame pulse, so a frame never mixes two alignments. Switching memory, clock recovery and output-side timing belong to other blocks.

Top module: `tdm_skew_rx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `frame_pulse`, `byte_valid` stays low. During reset `rx_byte` and `rx_chan` read zero.
- R2: The clock in which `frame_pulse` is high is frame position 0. The position advances by one per clock and wraps after CHANNELS*32 clocks. A pulse at any position restarts the count at 0 from that clock.
- R3: Bit 7 of channel 0 is the first bit of the frame, and the bits of each channel arrive most significant first. The block raises `byte_valid` for one clock, one clock after the clock that samples bit 0 of channel c. In that clock `rx_chan` equals c and `rx_byte` holds the eight samples with the earliest in bit 7.
- R4: `sample_late` = 1 samples 3 clocks into the bit cell (three quarters). `sample_late` = 0 samples 2 clocks into the bit cell (halfway). The reset default is 1.
- R5: A lane's delay code D (0 to 31, reset default 0) adds D clocks. Bit k of the frame (k = 8*channel + 7 - bit) is sampled at frame position (4k + D + M) mod (CHANNELS*32), where M is 3 or 2 as set in R4. Samples that fall beyond the frame end land at the start of the next frame, so the last channels of a frame are delivered in the next frame.
- R6: Delay codes and `sample_late` are captured in the pulse clock and used from that clock on. Changes between pulses have no effect on sampling until the next pulse.
- R7: Lanes are independent. Lane i reads `rx_line[i]` and its delay from `lane_delay[5i+4:5i]`. It drives `byte_valid[i]`, `rx_byte[8i+7:8i]` and `rx_chan[CW*i+CW-1:CW*i]`, where CW = log2(CHANNELS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four clocks per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-clock frame start marker |
| sample_late | input | 1 | 1: sample at 3/4 of the cell, 0: at 2/4 |
| rx_line | input | LANES | Serial data, one bit per lane |
| lane_delay | input | 5*LANES | Per-lane delay code in quarter bits |
| byte_valid | output | LANES | Per-lane byte strobe |
| rx_byte | output | 8*LANES | Per-lane assembled byte |
| rx_chan | output | CW*LANES | Per-lane channel number of the byte |

## Verification
Suppose the frame position counter is wrong. Then every following byte of every lane comes out with a wrong channel number or with no strobe at all, and this shows within one channel time of 32 clocks. Suppose instead a lane's sampling offset is off by a single quarter bit. The bench drives a line that carries a distinct value in every quarter-bit clock, so such an error changes the assembled bytes at the next strobe. Suppose a shadowed delay or mode takes effect mid-frame. Then the bytes change in the same frame as the write, before the next pulse.

// File: rtl/tdm_skew_pkg.sv
`timescale 1ns/1ps
// Shared constants for the skew-aligning TDM receiver.
// Assumes four system clocks per serial bit and eight bits per channel.
package tdm_skew_pkg;
    localparam int DLY_W   = 5;                 // delay code width, quarter-bit units
    localparam int BYTE_W  = 8;                 // bits per channel
    localparam int QTR_W   = 2;                 // log2 of clocks per bit
    localparam int BIT_W   = 3;                 // log2 of bits per channel
    localparam int CH_LSB  = QTR_W + BIT_W;     // position bit where channel index starts
    localparam int CLK_PER_CH = 1 << CH_LSB;    // clocks per channel time

    // Offset inside a bit cell, in clocks, for the chosen sampling point.
    function automatic logic [2:0] cell_bias(input logic late);
        return late ? 3'd3 : 3'd2;
    endfunction
endpackage

// File: rtl/tdm_skew_timer.sv
`timescale 1ns/1ps
// Frame position counter.
// Counts system clocks from the frame pulse. The pulse clock is position 0.
// The count wraps at FRAME_CLKS and restarts on every pulse. live_o goes high
// with the first pulse after reset and stays high.
// Assumes the pulse is one clock wide.
module tdm_skew_timer #(
    parameter int FRAME_CLKS = 16384,
    localparam int PW = $clog2(FRAME_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse_i,
    output logic [PW-1:0] pos_o,
    output logic          live_o
);
    logic [PW-1:0] pos_q;
    logic          live_q;

    // Current position: forced to zero in the pulse clock.
    assign pos_o  = pulse_i ? '0 : pos_q;
    assign live_o = live_q | pulse_i;

    // Advance the position and remember that a frame has started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            live_q <= 1'b0;
        end else begin
            pos_q  <= (pos_o == PW'(FRAME_CLKS - 1)) ? '0 : pos_o + PW'(1);
            live_q <= live_o;
        end
    end
endmodule

// File: rtl/tdm_skew_cfg.sv
`timescale 1ns/1ps
// Frame-synchronous configuration shadow.
// Captures every lane's delay code and the global sampling-point choice in
// the pulse clock. In that clock the new values are passed straight through,
// so the first sample of a frame already uses them.
// Assumes the delay fields are packed lane 0 in the lowest bits.
module tdm_skew_cfg #(
    parameter int LANES = 16,
    localparam int DW = tdm_skew_pkg::DLY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse_i,
    input  logic [LANES*DW-1:0] dly_i,
    input  logic                late_i,
    output logic [LANES*DW-1:0] dly_o,
    output logic                late_o
);
    logic [LANES*DW-1:0] dly_q;
    logic                late_q;

    // Bypass in the pulse clock, shadow otherwise.
    assign dly_o  = pulse_i ? dly_i  : dly_q;
    assign late_o = pulse_i ? late_i : late_q;

    // Capture the settings at each frame pulse; reset to no delay, 3/4 point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= '0;
            late_q <= 1'b1;
        end else if (pulse_i) begin
            dly_q  <= dly_i;
            late_q <= late_i;
        end
    end
endmodule

// File: rtl/tdm_skew_lane.sv
`timescale 1ns/1ps
// One receive lane.
// Subtracts the lane's sampling offset (delay plus cell bias) from the frame
// position, modulo the frame length. The result tells whether this clock is
// a sampling clock, which bit of the frame it samples, and which channel
// that bit belongs to. On the last bit of a channel the byte is registered
// out with its channel index and a one-clock strobe.
// Assumes FRAME_CLKS exceeds the largest offset (31 + 3 clocks).
module tdm_skew_lane #(
    parameter int FRAME_CLKS = 16384,
    localparam int PW = $clog2(FRAME_CLKS),
    localparam int CW = PW - tdm_skew_pkg::CH_LSB,
    localparam int DW = tdm_skew_pkg::DLY_W,
    localparam int BW = tdm_skew_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos_i,
    input  logic          live_i,
    input  logic [DW-1:0] dly_i,
    input  logic          late_i,
    input  logic          line_i,
    output logic          vld_o,
    output logic [BW-1:0] byte_o,
    output logic [CW-1:0] chan_o
);
    import tdm_skew_pkg::*;

    logic [PW-1:0] offset;
    logic [PW-1:0] rel;
    logic          take;
    logic          last_bit;
    logic [BW-1:0] shreg_q;
    logic [BW-1:0] next_shreg;

    // Sampling offset in clocks from frame position 0.
    assign offset = PW'(dly_i) + PW'(cell_bias(late_i));

    // Position relative to the lane's first sampling clock, modulo the frame.
    always_comb begin
        if (pos_i >= offset) begin
            rel = pos_i - offset;
        end else begin
            rel = pos_i + PW'(FRAME_CLKS) - offset;
        end
    end

    // Sample on the quarter that starts a bit; the last bit closes a channel.
    assign take       = live_i && (rel[QTR_W-1:0] == '0);
    assign last_bit   = (rel[CH_LSB-1:QTR_W] == {BIT_W{1'b1}});
    assign next_shreg = {shreg_q[BW-2:0], line_i};

    // Shift in one sample per bit, earliest bit ending up most significant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (take) begin
            shreg_q <= next_shreg;
        end
    end

    // Present the completed byte and its channel for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            byte_o <= '0;
            chan_o <= '0;
        end else begin
            vld_o <= take && last_bit;
            if (take && last_bit) begin
                byte_o <= next_shreg;
                chan_o <= rel[PW-1:CH_LSB];
            end
        end
    end
endmodule

// File: rtl/tdm_skew_rx.sv
`timescale 1ns/1ps
// Skew-aligning TDM serial receiver, top level.
// One frame timer and one configuration shadow are shared by LANES receive
// lanes. Each lane samples its line at a per-lane quarter-bit delay and
// delivers channel bytes with a channel index.
// Assumes four system clocks per bit and CHANNELS >= 2.
module tdm_skew_rx #(
    parameter int LANES    = 16,
    parameter int CHANNELS = 512,
    localparam int FRAME_CLKS = CHANNELS * tdm_skew_pkg::CLK_PER_CH,
    localparam int PW = $clog2(FRAME_CLKS),
    localparam int CW = $clog2(CHANNELS),
    localparam int DW = tdm_skew_pkg::DLY_W,
    localparam int BW = tdm_skew_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_pulse,
    input  logic                sample_late,
    input  logic [LANES-1:0]    rx_line,
    input  logic [LANES*DW-1:0] lane_delay,
    output logic [LANES-1:0]    byte_valid,
    output logic [LANES*BW-1:0] rx_byte,
    output logic [LANES*CW-1:0] rx_chan
);
    logic [PW-1:0]       frm_pos;
    logic                frm_live;
    logic [LANES*DW-1:0] cfg_dly;
    logic                cfg_late;

    tdm_skew_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (frame_pulse),
        .pos_o   (frm_pos),
        .live_o  (frm_live)
    );

    tdm_skew_cfg #(.LANES(LANES)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (frame_pulse),
        .dly_i   (lane_delay),
        .late_i  (sample_late),
        .dly_o   (cfg_dly),
        .late_o  (cfg_late)
    );

    // One lane per serial input.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tdm_skew_lane #(.FRAME_CLKS(FRAME_CLKS)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .pos_i  (frm_pos),
            .live_i (frm_live),
            .dly_i  (cfg_dly[g*DW +: DW]),
            .late_i (cfg_late),
            .line_i (rx_line[g]),
            .vld_o  (byte_valid[g]),
            .byte_o (rx_byte[g*BW +: BW]),
            .chan_o (rx_chan[g*CW +: CW])
        );
    end
endmodule

// File: rtl/tdm_skew_rx_chk.sv
`timescale 1ns/1ps
// Property checker for tdm_skew_rx, attached through bind.
// Watches the frame timer, the configuration shadow and the byte strobes.
module tdm_skew_rx_chk #(
    parameter int LANES    = 16,
    parameter int CHANNELS = 512,
    localparam int FRAME_CLKS = CHANNELS * tdm_skew_pkg::CLK_PER_CH,
    localparam int PW = $clog2(FRAME_CLKS),
    localparam int DW = tdm_skew_pkg::DLY_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_pulse,
    input logic [LANES-1:0]    byte_valid,
    input logic [PW-1:0]       frm_pos,
    input logic                frm_live,
    input logic [LANES*DW-1:0] cfg_dly,
    input logic                cfg_late
);
    logic seen_q;

    // Track whether a frame pulse has arrived since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (frame_pulse) seen_q <= 1'b1;
    end

    AST_QUIET_BEFORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|byte_valid) |-> seen_q);                                        // R1
    AST_LIVE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_live) |-> frame_pulse);                                 // R1
    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (frame_pulse || frm_pos == PW'(1)));              // R2
    AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !frame_pulse && $past(frm_pos) != PW'(FRAME_CLKS - 1))
        |-> frm_pos == $past(frm_pos) + PW'(1));                          // R2
    AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !frame_pulse) |-> $stable(cfg_dly));             // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !frame_pulse) |-> $stable(cfg_late));            // R6
endmodule

bind tdm_skew_rx tdm_skew_rx_chk #(.LANES(LANES), .CHANNELS(CHANNELS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .byte_valid  (byte_valid),
    .frm_pos     (frm_pos),
    .frm_live    (frm_live),
    .cfg_dly     (cfg_dly),
    .cfg_late    (cfg_late)
);

// File: tb/test_tdm_skew_rx.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task models each clock edge from the
// requirements and queues the expected bytes; a monitor compares strobes.
module test_tdm_skew_rx;
    localparam int LANES = 2;
    localparam int CHANNELS = 4;
    localparam int FRAME = CHANNELS * 32;
    localparam int CW = $clog2(CHANNELS);

    logic clk = 1'b0;
    logic rst_n;
    logic frame_pulse;
    logic sample_late;
    logic [LANES-1:0] rx_line;
    logic [LANES*5-1:0] lane_delay;
    logic [LANES-1:0] byte_valid;
    logic [LANES*8-1:0] rx_byte;
    logic [LANES*CW-1:0] rx_chan;

    always #4 clk = ~clk;

    tdm_skew_rx #(.LANES(LANES), .CHANNELS(CHANNELS)) i_tdm_skew_rx (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .sample_late(sample_late), .rx_line(rx_line), .lane_delay(lane_delay),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .rx_chan(rx_chan)
    );

    typedef struct { int edge_n; logic [7:0] b; int ch; } exp_t;
    exp_t sb [LANES][$];

    int checks = 0, errors = 0, cyc = 0, last_edge = 32'h7fffffff;
    bit done = 0, use_struct = 0, fp_en = 0, st_off = 0;
    int fpos = 0, pulses = 0;
    int sk [LANES];
    string ph_req = "R1", st_req = "R3";
    // reference model state
    int mpos = 0, mdel [LANES];
    bit msync = 0, mmode = 1;
    logic [7:0] msh [LANES];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] byte_of(int s, int ch);
        return 8'((ch * 37 + s * 91 + 11) & 255);
    endfunction

    // Line level: a designed byte stream skewed by sk quarters, or a
    // per-clock pseudo-random level.
    function automatic logic line_val(int s, int edge_n, int p);
        logic [31:0] h;
        int bi;
        logic [7:0] v;
        if (use_struct) begin
            bi = ((p - sk[s] + FRAME) % FRAME) / 4;
            v = byte_of(s, bi / 8);
            return v[7 - bi % 8];
        end
        h = 32'(edge_n) * 32'h9E3779B1 ^ 32'(s + 1) * 32'h85EBCA77;
        h = h ^ (h >> 15);
        return h[7];
    endfunction

    // Model one edge from the requirements (R2, R4, R5, R6) and queue bytes.
    task automatic model_edge(int edge_n);
        int cur, d, off, rel;
        bit lt, live;
        logic [7:0] nb;
        cur = frame_pulse ? 0 : mpos;
        live = msync || frame_pulse;
        for (int s = 0; s < LANES; s++) begin
            d = frame_pulse ? int'(lane_delay[s*5 +: 5]) : mdel[s];
            lt = frame_pulse ? sample_late : mmode;
            off = d + (lt ? 3 : 2);
            rel = (cur - off + FRAME) % FRAME;
            if (live && rel % 4 == 0) begin
                nb = {msh[s][6:0], rx_line[s]};
                msh[s] = nb;
                if ((rel / 4) % 8 == 7) sb[s].push_back('{edge_n, nb, rel / 32});
            end
        end
        mpos = (cur + 1) % FRAME;
        msync = live;
        if (frame_pulse) begin
            for (int s = 0; s < LANES; s++) mdel[s] = int'(lane_delay[s*5 +: 5]);
            mmode = sample_late;
        end
    endtask

    // Drive one clock of stimulus, model it, then wait for the edge to pass.
    task automatic step(bit force_fp);
        bit fp;
        fp = force_fp || (fp_en && fpos == 0);
        if (fp) begin
            fpos = 0;
            pulses++;
        end
        frame_pulse = fp;
        for (int s = 0; s < LANES; s++) rx_line[s] = line_val(s, cyc + 1, fpos);
        model_edge(cyc + 1);
        fpos = (fpos + 1) % FRAME;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic run_to(int p);
        do step(1'b0); while (fpos != p);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: compare every strobe and every expected byte at the negedge.
    always @(negedge clk) begin
        if (rst_n && !done && cyc <= last_edge) begin
            for (int s = 0; s < LANES; s++) begin
                bit ex;
                exp_t e;
                logic [7:0] ab;
                int ac;
                ex = sb[s].size() > 0 && sb[s][0].edge_n == cyc;
                e = ex ? sb[s][0] : '{0, 8'h00, 0};
                ab = rx_byte[s*8 +: 8];
                ac = int'(rx_chan[s*CW +: CW]);
                if (ex) void'(sb[s].pop_front());
                if (ex || byte_valid[s]) begin
                    checks++;
                    if (!(ex && byte_valid[s] && ab == e.b && ac == e.ch)) begin
                        errors++;
                        $display("FAIL %s lane %0d edge %0d: valid=%0b byte=%02h chan=%0d expected valid=%0b byte=%02h chan=%0d",
                                 ph_req, s, cyc, byte_valid[s], ab, ac, ex, e.b, e.ch);
                    end
                end
                // Designed-stream check, independent of the edge model.
                if (byte_valid[s] && use_struct && pulses >= 2 && !st_off) begin
                    checks++;
                    if (ab != byte_of(s, ac)) begin
                        errors++;
                        $display("FAIL %s lane %0d chan %0d: byte=%02h expected=%02h",
                                 st_req, s, ac, ab, byte_of(s, ac));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        frame_pulse = 1'b0;
        sample_late = 1'b1;
        rx_line = '0;
        lane_delay = '0;
        for (int s = 0; s < LANES; s++) begin
            mdel[s] = 0;
            msh[s] = 8'h00;
            sk[s] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        check(byte_valid == '0 && rx_byte == '0 && rx_chan == '0, "R1",
              "outputs in reset", int'(byte_valid) + int'(rx_byte), 0);
        rst_n = 1'b1;

        // R1: no strobe before the first pulse
        ph_req = "R1";
        fp_en = 0;
        run(40);
        check(byte_valid == '0, "R1", "valid before first pulse", int'(byte_valid), 0);

        // R3/R7: designed bytes, lane skews 0 and 5, delays 0 and 2, 3/4 point
        ph_req = "R3"; st_req = "R7";
        use_struct = 1; sk[0] = 0; sk[1] = 5;
        lane_delay = {5'd2, 5'd0}; sample_late = 1'b1;
        pulses = 0; fp_en = 1; fpos = 0;
        run(FRAME * 3);
        // R6: mid-frame writes must not disturb the current frame
        run_to(60);
        st_req = "R6"; ph_req = "R6";
        lane_delay = {5'd20, 5'd13}; sample_late = 1'b0;
        run_to(120);
        lane_delay = {5'd2, 5'd0}; sample_late = 1'b1;
        run(FRAME * 2);
        run_to(0);

        // R4/R5: halfway point, large delays that wrap into the next frame
        ph_req = "R4"; st_req = "R5";
        sk[0] = 9; sk[1] = 30;
        lane_delay = {5'd31, 5'd10}; sample_late = 1'b0;
        pulses = 0;
        run(FRAME * 4);
        run_to(0);

        // R6/R7: pseudo-random lines, settings rewritten inside each frame
        ph_req = "R6";
        use_struct = 0;
        for (int f = 0; f < 4; f++) begin
            run_to(37);
            lane_delay = {5'((f * 11 + 3) % 32), 5'((f * 13 + 7) % 32)};
            run_to(77);
            sample_late = ~sample_late;
            run_to(0);
        end

        // R2: early pulse realigns the frame
        ph_req = "R2"; st_req = "R2";
        use_struct = 1; sk[0] = 6; sk[1] = 1;
        lane_delay = {5'd1, 5'd6}; sample_late = 1'b1;
        pulses = 0;
        run(FRAME * 2 + 50);
        pulses = 0;
        step(1'b1);
        run(FRAME * 3);

        last_edge = cyc;
        @(negedge clk);
        @(negedge clk);
        for (int s = 0; s < LANES; s++)
            check(sb[s].size() == 0, "R3", "bytes never delivered", sb[s].size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule